// File: doc/BRIEF.md
# Compare-Branch Fusing Predecoder

This block sits between instruction predecode and a bank of parallel decoders. Each cycle it receives a window of up to `WIN` predecoded instructions, each tagged with a two-bit class and carrying an opcode field. It looks for a compare-type instruction whose immediate neighbour in the window is a conditional branch. When it finds one, it merges the two into a single fused record, and a decoder turns that record into one micro-op.

No more than one pair is merged per cycle. When several pairs qualify, the earliest one in program order wins. A mode input turns merging off entirely.

Results are packed into `DEC` decoder slots in program order. A merged pair therefore takes a single slot, and the instruction that follows it moves up by one. The block reports how many window entries it used, so the front end can advance by that amount. A running counter of merged pairs supports performance monitoring. All outputs are registered, so a window presented before a rising edge appears on the outputs just after that edge. `WIN` must be greater than `DEC`.

Top module: `fuse_predec`

## Requirements
- R1: While reset is asserted (synchronous, active low), every decoder slot is invalid and not fused, the used-entry count is zero and the fusion counter is zero.
- R2: Window entry j (class bits `in_cls[2j+1:2j]`) is merged with entry j+1 only when fusion is enabled, both entries lie below `in_cnt`, entry j has class 2'b01 (compare) and entry j+1 has class 2'b10 (conditional branch). Classes 2'b00 and 2'b11 never take part in a merge.
- R3: At most one pair is merged per window. When more than one pair qualifies, only the lowest-index pair is merged, and the later pairs pass through as ordinary single records.
- R4: A merged record holds the compare opcode in bits [2*OPW-1:OPW] and the branch opcode in bits [OPW-1:0] of its slot's micro-op field. An unmerged record holds its own opcode in the low half, with zero in the high half.
- R5: Decoder slots are filled from slot 0 upward in program order, with no gaps. Each valid window entry occupies one slot, except that a merged pair shares one slot. Filling stops when the entries or the slots run out.
- R6: With `fuse_en` low, no slot is marked fused and every entry appears as its own record.
- R7: `out_take` equals the number of window entries that the emitted slots represent: one per unmerged slot and two for a merged slot.
- R8: A merge never crosses the window edge. A compare in the last valid entry (index `in_cnt`-1) is not merged, even if the class field of the following, invalid, entry reads as a branch.
- R9: `fuse_cnt` increases by exactly one for each window that produces a merged slot, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_en | input | 1 | High enables compare-branch merging |
| in_cnt | input | $clog2(WIN+1) | Number of valid entries, counted from entry 0 |
| in_cls | input | 2*WIN | Class tag per entry, entry j at bits [2j+1:2j] |
| in_op | input | OPW*WIN | Opcode per entry, entry j at bits [OPW*j+OPW-1:OPW*j] |
| out_vld | output | DEC | Decoder slot holds a record |
| out_fus | output | DEC | Decoder slot holds a merged pair |
| out_uop | output | 2*OPW*DEC | Micro-op field per slot, slot k at bits [2*OPW*k+2*OPW-1:2*OPW*k] |
| out_take | output | $clog2(WIN+1) | Window entries used by this cycle's slots |
| fuse_cnt | output | CW | Count of merged pairs produced |

## Verification
The cases hardest to reach from the ports are the edge-of-window cases. In one, a compare sits in the last valid entry while the stale class bits beyond `in_cnt` spell a branch. In another, two or three pairs qualify in the same window and only the first may merge. The stimulus reaches both by sweeping every class pattern over all five entries, for every `in_cnt` value and both settings of `fuse_en`. Each window is compared against a slot-by-slot walk computed in the bench, and the opcodes differ for every entry and pattern, so a slot that is misplaced or shifted shows up in the micro-op field.

// File: rtl/fuse_predec.sv
module fuse_predec #(
  parameter int WIN = 5,
  parameter int DEC = 4,
  parameter int OPW = 8,
  parameter int CW  = 16,
  localparam int NW = $clog2(WIN + 1),
  localparam int PW = (WIN > 2) ? $clog2(WIN) : 1,
  localparam int UW = 2 * OPW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fuse_en,
  input  logic [NW-1:0]      in_cnt,
  input  logic [2*WIN-1:0]   in_cls,
  input  logic [OPW*WIN-1:0] in_op,
  output logic [DEC-1:0]     out_vld,
  output logic [DEC-1:0]     out_fus,
  output logic [UW*DEC-1:0]  out_uop,
  output logic [NW-1:0]      out_take,
  output logic [CW-1:0]      fuse_cnt
);

  localparam logic [1:0] CLS_CMP = 2'b01;
  localparam logic [1:0] CLS_BR  = 2'b10;

  logic [WIN-2:0] hit;
  logic           any_hit;
  logic [PW-1:0]  pos;
  logic           fuse_now;

  for (genvar j = 0; j < WIN - 1; j++) begin : g_hit
    assign hit[j] = fuse_en && (NW'(j + 1) < in_cnt) &&
                    in_cls[2*j +: 2] == CLS_CMP && in_cls[2*(j+1) +: 2] == CLS_BR;
  end

  always_comb begin
    any_hit = 1'b0;
    pos     = '0;
    for (int j = WIN - 2; j >= 0; j--) begin
      if (hit[j]) begin
        any_hit = 1'b1;
        pos     = PW'(j);
      end
    end
  end

  assign fuse_now = any_hit && (int'(pos) < DEC);

  logic [DEC-1:0]    nx_vld, nx_fus;
  logic [UW*DEC-1:0] nx_uop;
  logic [NW-1:0]     nx_take;

  for (genvar k = 0; k < DEC; k++) begin : g_slot
    logic          past_pair;
    logic [PW:0]   src;
    logic [OPW-1:0] lo_op, hi_op;
    assign past_pair  = fuse_now && (int'(pos) < k);
    assign src        = past_pair ? (PW+1)'(k + 1) : (PW+1)'(k);
    assign nx_fus[k]  = fuse_now && (int'(pos) == k);
    assign nx_vld[k]  = (int'(src) < int'(in_cnt));
    assign hi_op      = in_op[OPW*k +: OPW];
    assign lo_op      = nx_fus[k] ? in_op[OPW*(k+1) +: OPW] : in_op[OPW*int'(src) +: OPW];
    assign nx_uop[UW*k +: UW] = !nx_vld[k] ? '0 :
                                nx_fus[k]  ? {hi_op, lo_op} : {{OPW{1'b0}}, lo_op};
  end

  always_comb begin
    int lim;
    lim = fuse_now ? DEC + 1 : DEC;
    nx_take = (int'(in_cnt) < lim) ? in_cnt : NW'(lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_fus  <= '0;
      out_uop  <= '0;
      out_take <= '0;
      fuse_cnt <= '0;
    end else begin
      out_vld  <= nx_vld;
      out_fus  <= nx_fus;
      out_uop  <= nx_uop;
      out_take <= nx_take;
      fuse_cnt <= fuse_cnt + CW'(fuse_now);
    end
  end

endmodule

// File: rtl/fuse_predec_chk.sv
module fuse_predec_chk #(
  parameter int WIN = 5,
  parameter int DEC = 4,
  parameter int OPW = 8,
  parameter int CW  = 16,
  localparam int NW = $clog2(WIN + 1),
  localparam int UW = 2 * OPW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fuse_en,
  input logic [NW-1:0]      in_cnt,
  input logic [DEC-1:0]     out_vld,
  input logic [DEC-1:0]     out_fus,
  input logic [NW-1:0]      out_take,
  input logic [CW-1:0]      fuse_cnt
);

  p_one_fuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_fus));

  p_fus_has_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fus & ~out_vld) == '0);

  p_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld + DEC'(1)) & out_vld) == '0);

  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse_en |=> out_fus == '0);

  p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_take <= $past(in_cnt));

  p_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fuse_cnt == $past(fuse_cnt) + CW'($countones(out_fus)));

endmodule

bind fuse_predec fuse_predec_chk #(.WIN(WIN), .DEC(DEC), .OPW(OPW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en), .in_cnt(in_cnt),
  .out_vld(out_vld), .out_fus(out_fus), .out_take(out_take), .fuse_cnt(fuse_cnt)
);

// File: tb/tb_fuse_predec.sv
`timescale 1ns/1ps
module tb_fuse_predec;
  localparam int WIN = 5, DEC = 4, OPW = 8, CW = 16;
  localparam int NW = $clog2(WIN + 1);
  localparam int UW = 2 * OPW;

  logic clk = 1'b0, rst_n = 1'b0, fuse_en = 1'b0;
  logic [NW-1:0]      in_cnt = '0;
  logic [2*WIN-1:0]   in_cls = '0;
  logic [OPW*WIN-1:0] in_op = '0;
  logic [DEC-1:0]     out_vld, out_fus;
  logic [UW*DEC-1:0]  out_uop;
  logic [NW-1:0]      out_take;
  logic [CW-1:0]      fuse_cnt;

  always #2.5 clk = ~clk;

  fuse_predec #(.WIN(WIN), .DEC(DEC), .OPW(OPW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en), .in_cnt(in_cnt),
    .in_cls(in_cls), .in_op(in_op), .out_vld(out_vld), .out_fus(out_fus),
    .out_uop(out_uop), .out_take(out_take), .fuse_cnt(fuse_cnt));

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [CW-1:0] exp_cnt = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld == '0 && out_fus == '0, "R1 slots", {out_vld, out_fus}, 0);
    chk(out_take == '0, "R1 take", out_take, 0);
    chk(fuse_cnt == '0, "R1 counter", fuse_cnt, 0);
    rst_n = 1'b1;
    for (int en = 0; en < 2; en++) begin
      for (int cnt = 0; cnt <= WIN; cnt++) begin
        for (int pat = 0; pat < (1 << (2 * WIN)); pat++) begin
          logic [1:0] cl [WIN];
          logic [OPW-1:0] op [WIN];
          logic [DEC-1:0] e_vld, e_fus;
          logic [UW*DEC-1:0] e_uop;
          int p, npairs, j, k;
          fuse_en = en[0];
          in_cnt  = NW'(cnt);
          in_cls  = (2*WIN)'(pat);
          for (int i = 0; i < WIN; i++) begin
            cl[i] = in_cls[2*i +: 2];
            op[i] = OPW'(pat * 7 + i * 29 + cnt * 3 + 1);
            in_op[OPW*i +: OPW] = op[i];
          end
          p = -1; npairs = 0;
          for (int i = 0; i + 1 < cnt; i++)
            if (cl[i] == 2'b01 && cl[i+1] == 2'b10) begin
              npairs++;
              if (p < 0 && en == 1) p = i;
            end
          e_vld = '0; e_fus = '0; e_uop = '0;
          j = 0; k = 0;
          while (j < cnt && k < DEC) begin
            e_vld[k] = 1'b1;
            if (j == p) begin
              e_fus[k] = 1'b1;
              e_uop[UW*k +: UW] = {op[j], op[j+1]};
              j += 2;
            end else begin
              e_uop[UW*k +: UW] = {{OPW{1'b0}}, op[j]};
              j += 1;
            end
            k++;
          end
          if (p >= 0) exp_cnt = exp_cnt + 1'b1;
          @(negedge clk);
          chk(out_fus == e_fus, "R2 fused slot", out_fus, e_fus);
          chk(out_uop == e_uop, "R4 micro-op fields", out_uop, e_uop);
          chk(out_vld == e_vld, "R5 slot packing", out_vld, e_vld);
          chk(out_take == NW'(j), "R7 used entries", out_take, j);
          chk(fuse_cnt == exp_cnt, "R9 fusion counter", fuse_cnt, exp_cnt);
          if (en == 0)
            chk(out_fus == '0, "R6 fusion disabled", out_fus, 0);
          if (en == 1 && npairs >= 2)
            chk($countones(out_fus) == 1 && out_fus == e_fus, "R3 first pair only", out_fus, e_fus);
          if (en == 1 && npairs == 0 && cnt >= 1 && cnt < WIN &&
              cl[cnt-1] == 2'b01 && cl[cnt] == 2'b10)
            chk(out_fus == '0, "R8 window edge", out_fus, 0);
        end
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule